// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits beside the transmit and receive FIFOs of a serial peripheral controller and turns their fill levels and access strobes into status, interrupt and DMA request signals. It takes the two FIFO levels, a busy indication from the shift engine, and three access strobes: a write into the transmit FIFO, a read from the receive FIFO and a fill of the receive FIFO by the shift engine. From these it builds a five-bit status word, a five-source raw interrupt word, a masked view of that word, one interrupt line, and one DMA request for each direction.

Software configures the block through a single write port. A three-bit selector picks one of seven configuration targets: the interrupt mask, the clear register, the DMA enable bits, and four limit registers (the transmit and receive interrupt thresholds and the transmit and receive DMA levels). A limit register only takes a value that is smaller than the FIFO depth, so software can write rising values and read the thresholds back to learn the depth. The threshold interrupt sources follow the levels directly. The overflow and underflow sources are sticky until software clears them.

The block moves no data, so it has no valid/ready interface. The strobes are single-cycle events, and each has a matching acceptance output that the FIFO uses to take or drop the access. There is no back-pressure. A transmit write while the FIFO is full is reported as not accepted and is flagged. It is never stalled.

Top module: `spi_fifo_stat_irq`

## Requirements
- R1: The status word carries busy on bit 0, transmit full on bit 1, transmit empty on bit 2, receive empty on bit 3 and receive full on bit 4. Full means the level equals the FIFO depth, and empty means the level is zero.
- R2: Raw interrupt bit 0 is set while the transmit level is at or below the transmit threshold. Raw bit 4 is set while the receive level is above the receive threshold. Neither bit is stored, and no clear write affects them.
- R3: A transmit write strobe while the transmit FIFO is full gives tx_push_ok_o low in that same cycle and sets raw bit 1 (transmit overflow) from the next cycle. A transmit write while the FIFO is not full is accepted.
- R4: A receive read strobe while the receive FIFO is empty gives rx_pop_ok_o low in that same cycle and sets raw bit 2 (receive underflow) from the next cycle. A receive read while the FIFO is not empty is accepted and sets no flag.
- R5: A receive fill strobe while the receive FIFO is full sets raw bit 3 (receive overflow) from the next cycle.
- R6: Writing the clear target clears flags in the next cycle. Bit 1 clears receive underflow, bit 2 clears receive overflow, bit 3 clears transmit overflow, and bit 0 clears all three.
- R7: When a flag's setting event and its clear fall in the same cycle, the flag ends up set.
- R8: The masked word equals the raw word ANDed with the five-bit mask. irq_o is high exactly when any masked bit is high.
- R9: Each limit register takes a written value only when that value is below the FIFO depth. Otherwise it keeps its previous value. Both thresholds can be read back on tx_thr_o and rx_thr_o.
- R10: In the DMA enable target, bit 0 enables the receive request and bit 1 enables the transmit request. The transmit request is high while it is enabled and the transmit level is at or below the transmit DMA level. The receive request is high while it is enabled and the receive level is above the receive DMA level.
- R11: After reset, the mask, the DMA enables, every limit register and every sticky flag are zero.
- R12: The selector codes are: 0 mask, 1 clear, 2 DMA enable, 3 transmit threshold, 4 receive threshold, 5 transmit DMA level, 6 receive DMA level, 7 none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Shift engine busy |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| tx_push_i | input | 1 | Write strobe into the transmit FIFO |
| rx_pop_i | input | 1 | Read strobe from the receive FIFO |
| rx_fill_i | input | 1 | Shift engine writes a word into the receive FIFO |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration target selector |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| status_o | output | 5 | Status word |
| raw_irq_o | output | 5 | Raw interrupt word |
| masked_irq_o | output | 5 | Masked interrupt word |
| irq_o | output | 1 | Interrupt line |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_push_ok_o | output | 1 | Transmit write accepted |
| rx_pop_ok_o | output | 1 | Receive read accepted |
| tx_thr_o | output | LVL_W | Transmit threshold readback |
| rx_thr_o | output | LVL_W | Receive threshold readback |

## Verification
Two functions can land on the same edge: a software clear of the sticky flags and a new overflow or underflow event that sets one of those flags. The bench holds the transmit FIFO full and, in a single cycle, raises the transmit write strobe together with a clear-all write. It then requires that transmit overflow stays set while the other flags clear. A later clear-all with no event present must leave all three flags clear, and the threshold bits must go on following the levels.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  typedef enum logic [2:0] {
    CFG_MASK   = 3'd0,
    CFG_CLEAR  = 3'd1,
    CFG_DMA_EN = 3'd2,
    CFG_TX_THR = 3'd3,
    CFG_RX_THR = 3'd4,
    CFG_TX_DMA = 3'd5,
    CFG_RX_DMA = 3'd6,
    CFG_NONE   = 3'd7
  } cfg_sel_e;

  localparam int ST_BUSY     = 0;
  localparam int ST_TX_FULL  = 1;
  localparam int ST_TX_EMPTY = 2;
  localparam int ST_RX_EMPTY = 3;
  localparam int ST_RX_FULL  = 4;

  localparam int IRQ_TX_THR = 0;
  localparam int IRQ_TX_OVF = 1;
  localparam int IRQ_RX_UDF = 2;
  localparam int IRQ_RX_OVF = 3;
  localparam int IRQ_RX_THR = 4;
  localparam int IRQ_W      = 5;

  localparam int CLR_ALL    = 0;
  localparam int CLR_RX_UDF = 1;
  localparam int CLR_RX_OVF = 2;
  localparam int CLR_TX_OVF = 3;

  // sticky flag slots
  localparam int FLG_TX_OVF = 0;
  localparam int FLG_RX_UDF = 1;
  localparam int FLG_RX_OVF = 2;
  localparam int FLG_N      = 3;

  localparam int DMA_EN_RX = 0;
  localparam int DMA_EN_TX = 1;

  // number of limit registers, selector codes are contiguous from CFG_TX_THR
  localparam int LIM_N      = 4;
  localparam int LIM_TX_THR = 0;
  localparam int LIM_RX_THR = 1;
  localparam int LIM_TX_DMA = 2;
  localparam int LIM_RX_DMA = 3;

endpackage

// File: rtl/sfs_limit_reg.sv
module sfs_limit_reg #(
  parameter int DEPTH  = 32,
  parameter int LVL_W  = $clog2(DEPTH + 1),
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LVL_W-1:0]  q_o
);
  localparam logic [DATA_W-1:0] DEPTH_D = DATA_W'(DEPTH);

  logic in_range;
  assign in_range = (wdata_i < DEPTH_D);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
    end else if (we_i && in_range) begin
      q_o <= wdata_i[LVL_W-1:0];
    end
  end

  AST_LIMIT_BELOW_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    q_o < LVL_W'(DEPTH)); // R9
  AST_LIMIT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (wdata_i >= DEPTH_D)) |=> $stable(q_o)); // R9
endmodule

// File: rtl/sfs_sticky_flags.sv
module sfs_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_o[i] <= 1'b0;
      end else if (set_i[i]) begin
        q_o[i] <= 1'b1;
      end else if (clr_i[i]) begin
        q_o[i] <= 1'b0;
      end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q_o[i]); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]); // R6
  end
endmodule

// File: rtl/sfs_level_eval.sv
module sfs_level_eval #(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             busy_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_thr_i,
  input  logic [LVL_W-1:0] rx_thr_i,
  input  logic [LVL_W-1:0] tx_dma_lvl_i,
  input  logic [LVL_W-1:0] rx_dma_lvl_i,
  input  logic [1:0]       dma_en_i,
  output logic [4:0]       status_o,
  output logic             tx_full_o,
  output logic             rx_full_o,
  output logic             rx_empty_o,
  output logic             tx_thr_hit_o,
  output logic             rx_thr_hit_o,
  output logic             tx_dma_req_o,
  output logic             rx_dma_req_o
);
  import sfs_pkg::*;

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic tx_empty;

  always_comb begin
    tx_full_o  = (tx_level_i == FULL_LVL);
    rx_full_o  = (rx_level_i == FULL_LVL);
    tx_empty   = (tx_level_i == '0);
    rx_empty_o = (rx_level_i == '0);

    status_o              = '0;
    status_o[ST_BUSY]     = busy_i;
    status_o[ST_TX_FULL]  = tx_full_o;
    status_o[ST_TX_EMPTY] = tx_empty;
    status_o[ST_RX_EMPTY] = rx_empty_o;
    status_o[ST_RX_FULL]  = rx_full_o;

    tx_thr_hit_o = (tx_level_i <= tx_thr_i);
    rx_thr_hit_o = (rx_level_i >  rx_thr_i);

    tx_dma_req_o = dma_en_i[DMA_EN_TX] && (tx_level_i <= tx_dma_lvl_i);
    rx_dma_req_o = dma_en_i[DMA_EN_RX] && (rx_level_i >  rx_dma_lvl_i);
  end
endmodule

// File: rtl/spi_fifo_stat_irq.sv
module spi_fifo_stat_irq #(
  parameter int DEPTH  = 32,
  parameter int LVL_W  = $clog2(DEPTH + 1),
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic              tx_push_i,
  input  logic              rx_pop_i,
  input  logic              rx_fill_i,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [4:0]        status_o,
  output logic [4:0]        raw_irq_o,
  output logic [4:0]        masked_irq_o,
  output logic              irq_o,
  output logic              tx_dma_req_o,
  output logic              rx_dma_req_o,
  output logic              tx_push_ok_o,
  output logic              rx_pop_ok_o,
  output logic [LVL_W-1:0]  tx_thr_o,
  output logic [LVL_W-1:0]  rx_thr_o
);
  import sfs_pkg::*;

  logic [IRQ_W-1:0] mask_q;
  logic [1:0]       dma_en_q;
  logic [LVL_W-1:0] lim_q [LIM_N];

  // limit registers: thresholds and DMA levels
  for (genvar g = 0; g < LIM_N; g++) begin : g_lim
    logic lim_we;
    assign lim_we = cfg_we_i && (cfg_sel_i == 3'(int'(CFG_TX_THR) + g));
    sfs_limit_reg #(.DEPTH(DEPTH), .LVL_W(LVL_W), .DATA_W(DATA_W)) u_lim (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (lim_we),
      .wdata_i (cfg_wdata_i),
      .q_o     (lim_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      dma_en_q <= '0;
    end else if (cfg_we_i) begin
      if (cfg_sel_i == CFG_MASK)   mask_q   <= cfg_wdata_i[IRQ_W-1:0];
      if (cfg_sel_i == CFG_DMA_EN) dma_en_q <= cfg_wdata_i[1:0];
    end
  end

  logic tx_full, rx_full, rx_empty, tx_thr_hit, rx_thr_hit;

  sfs_level_eval #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_eval (
    .busy_i       (busy_i),
    .tx_level_i   (tx_level_i),
    .rx_level_i   (rx_level_i),
    .tx_thr_i     (lim_q[LIM_TX_THR]),
    .rx_thr_i     (lim_q[LIM_RX_THR]),
    .tx_dma_lvl_i (lim_q[LIM_TX_DMA]),
    .rx_dma_lvl_i (lim_q[LIM_RX_DMA]),
    .dma_en_i     (dma_en_q),
    .status_o     (status_o),
    .tx_full_o    (tx_full),
    .rx_full_o    (rx_full),
    .rx_empty_o   (rx_empty),
    .tx_thr_hit_o (tx_thr_hit),
    .rx_thr_hit_o (rx_thr_hit),
    .tx_dma_req_o (tx_dma_req_o),
    .rx_dma_req_o (rx_dma_req_o)
  );

  // error events and clear decode
  logic [FLG_N-1:0] flg_set, flg_clr, flg_q;
  logic             clr_we;

  assign clr_we = cfg_we_i && (cfg_sel_i == CFG_CLEAR);

  always_comb begin
    flg_set             = '0;
    flg_set[FLG_TX_OVF] = tx_push_i && tx_full;
    flg_set[FLG_RX_UDF] = rx_pop_i  && rx_empty;
    flg_set[FLG_RX_OVF] = rx_fill_i && rx_full;

    flg_clr             = '0;
    flg_clr[FLG_TX_OVF] = clr_we && (cfg_wdata_i[CLR_ALL] || cfg_wdata_i[CLR_TX_OVF]);
    flg_clr[FLG_RX_UDF] = clr_we && (cfg_wdata_i[CLR_ALL] || cfg_wdata_i[CLR_RX_UDF]);
    flg_clr[FLG_RX_OVF] = clr_we && (cfg_wdata_i[CLR_ALL] || cfg_wdata_i[CLR_RX_OVF]);
  end

  sfs_sticky_flags #(.N(FLG_N)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (flg_set),
    .clr_i (flg_clr),
    .q_o   (flg_q)
  );

  always_comb begin
    raw_irq_o             = '0;
    raw_irq_o[IRQ_TX_THR] = tx_thr_hit;
    raw_irq_o[IRQ_TX_OVF] = flg_q[FLG_TX_OVF];
    raw_irq_o[IRQ_RX_UDF] = flg_q[FLG_RX_UDF];
    raw_irq_o[IRQ_RX_OVF] = flg_q[FLG_RX_OVF];
    raw_irq_o[IRQ_RX_THR] = rx_thr_hit;
    masked_irq_o          = raw_irq_o & mask_q;
    irq_o                 = |masked_irq_o;
  end

  assign tx_push_ok_o = tx_push_i && !tx_full;
  assign rx_pop_ok_o  = rx_pop_i  && !rx_empty;
  assign tx_thr_o     = lim_q[LIM_TX_THR];
  assign rx_thr_o     = lim_q[LIM_RX_THR];

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q != '0)); // R8
  AST_TX_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req_o |-> dma_en_q[DMA_EN_TX]); // R10
  AST_RX_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req_o |-> dma_en_q[DMA_EN_RX]); // R10
  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_i && (status_o[ST_TX_FULL])) |-> !tx_push_ok_o); // R3
  AST_TXOVF_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_i && tx_full) |=> raw_irq_o[IRQ_TX_OVF]); // R3
endmodule

// File: tb/tb_spi_fifo_stat_irq.sv
`timescale 1ns/1ps
module tb_spi_fifo_stat_irq;
  localparam int DEPTH  = 32;
  localparam int LVL_W  = 6;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              busy_i = 1'b0;
  logic [LVL_W-1:0]  tx_level_i = '0;
  logic [LVL_W-1:0]  rx_level_i = '0;
  logic              tx_push_i = 1'b0;
  logic              rx_pop_i = 1'b0;
  logic              rx_fill_i = 1'b0;
  logic              cfg_we_i = 1'b0;
  logic [2:0]        cfg_sel_i = 3'd7;
  logic [DATA_W-1:0] cfg_wdata_i = '0;
  logic [4:0]        status_o, raw_irq_o, masked_irq_o;
  logic              irq_o, tx_dma_req_o, rx_dma_req_o, tx_push_ok_o, rx_pop_ok_o;
  logic [LVL_W-1:0]  tx_thr_o, rx_thr_o;

  spi_fifo_stat_irq #(.DEPTH(DEPTH), .LVL_W(LVL_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .tx_level_i(tx_level_i),
    .rx_level_i(rx_level_i), .tx_push_i(tx_push_i), .rx_pop_i(rx_pop_i),
    .rx_fill_i(rx_fill_i), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .status_o(status_o), .raw_irq_o(raw_irq_o),
    .masked_irq_o(masked_irq_o), .irq_o(irq_o), .tx_dma_req_o(tx_dma_req_o),
    .rx_dma_req_o(rx_dma_req_o), .tx_push_ok_o(tx_push_ok_o),
    .rx_pop_ok_o(rx_pop_ok_o), .tx_thr_o(tx_thr_o), .rx_thr_o(rx_thr_o)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] sel, input logic [DATA_W-1:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0; cfg_sel_i = 3'd7; cfg_wdata_i = '0;
  endtask

  // vector: tx_level, rx_level, busy, status, raw, tx_dma, rx_dma
  localparam int NV = 6;
  localparam logic [24:0] VEC [NV] = '{
    {6'd0,  6'd0,  1'b0, 5'h0C, 5'h01, 1'b1, 1'b0},
    {6'd32, 6'd32, 1'b1, 5'h13, 5'h10, 1'b0, 1'b1},
    {6'd8,  6'd21, 1'b0, 5'h00, 5'h11, 1'b0, 1'b1},
    {6'd9,  6'd20, 1'b1, 5'h01, 5'h00, 1'b0, 1'b1},
    {6'd4,  6'd10, 1'b0, 5'h00, 5'h01, 1'b1, 1'b0},
    {6'd5,  6'd11, 1'b0, 5'h00, 5'h01, 1'b0, 1'b1}
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state, R1 status with empty FIFOs
    check("R11 status", status_o, 5'h0C);
    check("R11 raw", raw_irq_o, 5'h01);
    check("R11 masked", masked_irq_o, 5'h00);
    check("R11 irq", irq_o, 1'b0);
    check("R11 dma", {tx_dma_req_o, rx_dma_req_o}, 2'b00);
    check("R11 thr", {tx_thr_o, rx_thr_o}, 12'h000);

    // R9 limit acceptance, R12 codes 3 and 4
    cfg_wr(3'd3, 16'd31); check("R9 tx thr 31", tx_thr_o, 6'd31);
    cfg_wr(3'd3, 16'd32); check("R9 tx thr 32 rejected", tx_thr_o, 6'd31);
    cfg_wr(3'd3, 16'hFFFF); check("R9 tx thr big rejected", tx_thr_o, 6'd31);
    cfg_wr(3'd4, 16'd33); check("R9 rx thr 33 rejected", rx_thr_o, 6'd0);
    cfg_wr(3'd4, 16'd20); check("R9 rx thr 20", rx_thr_o, 6'd20);

    // configuration for the table
    cfg_wr(3'd3, 16'd8);
    cfg_wr(3'd2, 16'h3);
    cfg_wr(3'd5, 16'd4);
    cfg_wr(3'd6, 16'd10);

    // table walk: R1 status, R2 threshold bits, R10 DMA requests
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      tx_level_i = VEC[i][24:19];
      rx_level_i = VEC[i][18:13];
      busy_i     = VEC[i][12];
      #1;
      check("R1 status", status_o, VEC[i][11:7]);
      check("R2 raw", raw_irq_o, VEC[i][6:2]);
      check("R10 tx dma", tx_dma_req_o, VEC[i][1]);
      check("R10 rx dma", rx_dma_req_o, VEC[i][0]);
    end
    busy_i = 1'b0;

    // R3 transmit overflow
    @(negedge clk);
    tx_level_i = 6'd32; rx_level_i = 6'd0;
    tx_push_i = 1'b1; #1;
    check("R3 push dropped", tx_push_ok_o, 1'b0);
    @(negedge clk); tx_push_i = 1'b0;
    check("R3 tx ovf set", raw_irq_o & 5'h0E, 5'h02);

    // R4 receive underflow
    rx_pop_i = 1'b1; #1;
    check("R4 pop refused", rx_pop_ok_o, 1'b0);
    @(negedge clk); rx_pop_i = 1'b0;
    check("R4 rx udf set", raw_irq_o & 5'h0E, 5'h06);

    // R5 receive overflow; R4 pop on non-empty accepted
    rx_level_i = 6'd32; rx_fill_i = 1'b1; rx_pop_i = 1'b1; #1;
    check("R4 pop accepted", rx_pop_ok_o, 1'b1);
    @(negedge clk); rx_fill_i = 1'b0; rx_pop_i = 1'b0;
    check("R5 rx ovf set", raw_irq_o & 5'h0E, 5'h0E);

    // R8 mask (code 0)
    cfg_wr(3'd0, 16'h0002);
    check("R8 masked", masked_irq_o, 5'h02);
    check("R8 irq on", irq_o, 1'b1);
    cfg_wr(3'd0, 16'h0000);
    check("R8 irq off", irq_o, 1'b0);

    // R6 selective clears (code 1)
    cfg_wr(3'd1, 16'h0008); check("R6 clr tx ovf", raw_irq_o & 5'h0E, 5'h0C);
    cfg_wr(3'd1, 16'h0002); check("R6 clr rx udf", raw_irq_o & 5'h0E, 5'h08);

    // R7 event and clear-all in the same cycle
    @(negedge clk);
    tx_push_i = 1'b1; cfg_we_i = 1'b1; cfg_sel_i = 3'd1; cfg_wdata_i = 16'h0001;
    @(negedge clk);
    tx_push_i = 1'b0; cfg_we_i = 1'b0; cfg_sel_i = 3'd7; cfg_wdata_i = '0;
    check("R7 set wins", raw_irq_o & 5'h0E, 5'h02);

    // R6 clear-all; R2 threshold bits untouched
    cfg_wr(3'd1, 16'h001F);
    check("R6 clr all", raw_irq_o & 5'h0E, 5'h00);
    check("R2 not clearable", raw_irq_o, 5'h10);

    // R10 enables
    tx_level_i = 6'd0;
    cfg_wr(3'd2, 16'h0);
    check("R10 dma off", {tx_dma_req_o, rx_dma_req_o}, 2'b00);
    cfg_wr(3'd2, 16'h1);
    check("R10 rx only", {tx_dma_req_o, rx_dma_req_o}, 2'b01);
    cfg_wr(3'd2, 16'h2);
    check("R10 tx only", {tx_dma_req_o, rx_dma_req_o}, 2'b10);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule